// File: doc/BRIEF.md
# Cache Block Maintenance Unit

This block is a small direct-mapped write-back data cache with a maintenance engine attached. The engine runs three per-line operations. Invalidate removes a line. Clean writes a modified line downstream and keeps it resident. Flush writes back and removes the line as one sequence that cannot be interrupted. Each command names exactly one block by its physical line address; there is no range or list form. One command runs at a time. While a command is in flight, both the command port and the cache access port are held not-ready.

A fill/store access port and a combinational probe port give the surrounding pipeline what it needs to populate the array and to look lines up. A dirty line leaves through a valid/ready write-back port that carries the byte-aligned line address and the full line data. Completion is a one-cycle `done` pulse. When the command used the reserved opcode, `err` is raised alongside `done`. The parameter `INVAL_AS_FLUSH` picks how invalidate treats modified data: it either discards it or writes it back before removing the line.

Top module: `cmo_unit`

## Requirements
- R1: `cmd_op` codes are 2'b00 invalidate, 2'b01 clean, 2'b10 flush. Code 2'b11 is reserved: it changes no line, makes no write-back, and completes with `err` high during the `done` cycle. `err` is never high without `done`.
- R2: With `INVAL_AS_FLUSH`=0, invalidate on a hit clears the line's valid bit and makes no write-back, even when the line is dirty.
- R3: With `INVAL_AS_FLUSH`=1, invalidate on a dirty hit writes the line back and then deallocates it. On a clean hit it deallocates with no write-back.
- R4: Clean on a dirty hit makes exactly one write-back, leaves the line valid with unchanged data, and clears its dirty bit, so a second clean makes no write-back. Clean on a clean hit makes no write-back.
- R5: Flush on a dirty hit makes one write-back and then deallocates. On a clean hit it deallocates with no write-back.
- R6: A command that misses (invalid line, or stored tag different from the address tag) changes no line and makes no write-back.
- R7: Only one operation is outstanding. `cmd_ready` and `acc_ready` are low from the cycle after acceptance until the cycle after the one-cycle `done` pulse.
- R8: Once `wb_valid` rises, it stays high with `wb_addr` and `wb_data` stable until `wb_ready` is seen.
- R9: Flush is indivisible. No access is accepted while a write-back is pending, and the line is deallocated in the cycle after the write-back handshake.
- R10: After reset every line is invalid, `cmd_ready` and `acc_ready` are high, and `wb_valid`, `done` and `err` are low.
- R11: The write-back address is the line address followed by zero offset bits (bits [2:0] for a 64-bit line). The data is the line's stored data.
- R12: Counting from the accepting clock edge, `done` is high in cycle 1 for a miss or reserved opcode and in cycle 2 for a hit with no write-back. On the write-back path it is high in the second cycle after the handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Maintenance command request |
| cmd_ready | output | 1 | Engine idle, command can be accepted |
| cmd_op | input | 2 | Operation code (see R1) |
| cmd_line | input | ADDR_W-OFF_W | Line address {tag, index} of the target block |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved opcode flag, valid with done |
| acc_valid | input | 1 | Fill/store request |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_write | input | 1 | 1 = store (line becomes dirty), 0 = fill (clean) |
| acc_line | input | ADDR_W-OFF_W | Line address of the access |
| acc_wdata | input | LINE_W | Line data written |
| probe_line | input | ADDR_W-OFF_W | Line address looked up |
| probe_hit | output | 1 | Probed line is valid with matching tag |
| probe_data | output | LINE_W | Data of the probed index |
| wb_valid | output | 1 | Write-back transfer offered |
| wb_ready | input | 1 | Downstream accepts the write-back |
| wb_addr | output | ADDR_W | Byte address of the written-back line |
| wb_data | output | LINE_W | Line data written back |

## Verification
The checker watches these properties on every cycle: command acceptance drops both ready outputs, `done` lasts exactly one cycle and never coincides with an idle engine, `err` appears only with `done`, a pending write-back holds its address and data stable, no access is accepted during a write-back, and `done` never arrives in the cycle right after a handshake. Only the bench's scenarios can show what each opcode actually does to a line. It sweeps every opcode across invalid, clean and dirty lines, both hits and tag misses, both invalidate modes and several ready delays. It then reads the surviving state back through the probe port and a follow-up clean.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

  typedef enum logic [1:0] {
    OP_INVAL = 2'b00,
    OP_CLEAN = 2'b01,
    OP_FLUSH = 2'b10,
    OP_RSVD  = 2'b11
  } cmo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_UPDATE,
    ST_DONE
  } cmo_state_e;

  // What a looked-up command will do to its line
  typedef struct packed {
    logic touch;      // line is modified in UPDATE
    logic wb;         // a write transfer precedes the update
    logic clr_valid;
    logic clr_dirty;
    logic err;        // reserved opcode
  } cmo_act_t;

endpackage

// File: rtl/cmo_line_store.sv
module cmo_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 6,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              fill_dirty,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_clr_valid,
  input  logic              upd_clr_dirty,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic              rda_valid,
  output logic [TAG_W-1:0]  rda_tag,
  output logic [LINE_W-1:0] rda_data,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic              rdb_valid,
  output logic              rdb_dirty,
  output logic [TAG_W-1:0]  rdb_tag,
  output logic [LINE_W-1:0] rdb_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [DEPTH-1:0]  drt_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  fill_sel;
  logic [DEPTH-1:0]  upd_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign fill_sel[g] = fill_en && (fill_idx == IDX_W'(g));
    assign upd_sel[g]  = upd_en  && (upd_idx  == IDX_W'(g));
  end

  // State bits: reset to invalid and clean
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      drt_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (fill_sel[i]) begin
          vld_q[i] <= 1'b1;
          drt_q[i] <= fill_dirty;
        end else if (upd_sel[i]) begin
          if (upd_clr_valid) vld_q[i] <= 1'b0;
          if (upd_clr_dirty) drt_q[i] <= 1'b0;
        end
      end
    end
  end

  // Tag and data arrays: no reset, written only on fill
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (fill_sel[i]) begin
        tag_q[i]  <= fill_tag;
        data_q[i] <= fill_data;
      end
    end
  end

  assign rda_valid = vld_q[rda_idx];
  assign rda_tag   = tag_q[rda_idx];
  assign rda_data  = data_q[rda_idx];
  assign rdb_valid = vld_q[rdb_idx];
  assign rdb_dirty = drt_q[rdb_idx];
  assign rdb_tag   = tag_q[rdb_idx];
  assign rdb_data  = data_q[rdb_idx];

endmodule

// File: rtl/cmo_act_dec.sv
module cmo_act_dec
  import cmo_pkg::*;
#(
  parameter bit INVAL_AS_FLUSH = 1'b0
) (
  input  cmo_op_e  op,
  input  logic     hit,
  input  logic     dirty,
  output cmo_act_t act
);

  always_comb begin
    act = '0;
    unique case (op)
      OP_INVAL: begin
        act.touch     = hit;
        act.wb        = hit && dirty && INVAL_AS_FLUSH;
        act.clr_valid = 1'b1;
        act.clr_dirty = 1'b1;
      end
      OP_CLEAN: begin
        act.touch     = hit;
        act.wb        = hit && dirty;
        act.clr_dirty = 1'b1;
      end
      OP_FLUSH: begin
        act.touch     = hit;
        act.wb        = hit && dirty;
        act.clr_valid = 1'b1;
        act.clr_dirty = 1'b1;
      end
      default: begin
        act.err = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl
  import cmo_pkg::*;
#(
  parameter int IDX_W          = 3,
  parameter int TAG_W          = 6,
  parameter bit INVAL_AS_FLUSH = 1'b0,
  localparam int LADDR_W       = IDX_W + TAG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [LADDR_W-1:0] cmd_line,
  output logic               cmd_ready,
  output logic               acc_ready,
  output logic [LADDR_W-1:0] line_q,
  input  logic               look_valid,
  input  logic               look_dirty,
  input  logic [TAG_W-1:0]   look_tag,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic               upd_en,
  output logic               upd_clr_valid,
  output logic               upd_clr_dirty,
  output logic               done,
  output logic               err
);

  cmo_state_e state_q, state_d;
  cmo_op_e    op_q;
  cmo_act_t   act_q, act_d;
  logic       hit;
  logic       accept;
  logic       look_en;

  assign accept  = cmd_valid && (state_q == ST_IDLE);
  assign look_en = (state_q == ST_LOOKUP);
  assign hit     = look_valid && (look_tag == line_q[LADDR_W-1 -: TAG_W]);

  cmo_act_dec #(.INVAL_AS_FLUSH(INVAL_AS_FLUSH)) u_dec (
    .op    (op_q),
    .hit   (hit),
    .dirty (look_dirty),
    .act   (act_d)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cmd_valid) state_d = ST_LOOKUP;
      ST_LOOKUP: begin
        if (!act_d.touch)   state_d = ST_DONE;
        else if (act_d.wb)  state_d = ST_WBACK;
        else                state_d = ST_UPDATE;
      end
      ST_WBACK:  if (wb_ready) state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Command capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_INVAL;
      line_q <= '0;
    end else if (accept) begin
      op_q   <= cmo_op_e'(cmd_op);
      line_q <= cmd_line;
    end
  end

  // Decision capture, enabled in the lookup cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= '0;
    else if (look_en) act_q <= act_d;
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign acc_ready     = (state_q == ST_IDLE);
  assign wb_valid      = (state_q == ST_WBACK);
  assign upd_en        = (state_q == ST_UPDATE);
  assign upd_clr_valid = act_q.clr_valid;
  assign upd_clr_dirty = act_q.clr_dirty;
  assign done          = (state_q == ST_DONE);
  assign err           = (state_q == ST_DONE) && act_q.err;

endmodule

// File: rtl/cmo_unit.sv
module cmo_unit #(
  parameter int  ADDR_W         = 12,
  parameter int  LINE_W         = 64,
  parameter int  IDX_W          = 3,
  parameter bit  INVAL_AS_FLUSH = 1'b0,
  localparam int OFF_W          = $clog2(LINE_W / 8),
  localparam int LADDR_W        = ADDR_W - OFF_W,
  localparam int TAG_W          = LADDR_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_op,
  input  logic [LADDR_W-1:0] cmd_line,
  output logic               done,
  output logic               err,
  input  logic               acc_valid,
  output logic               acc_ready,
  input  logic               acc_write,
  input  logic [LADDR_W-1:0] acc_line,
  input  logic [LINE_W-1:0]  acc_wdata,
  input  logic [LADDR_W-1:0] probe_line,
  output logic               probe_hit,
  output logic [LINE_W-1:0]  probe_data,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [LINE_W-1:0]  wb_data
);

  logic [LADDR_W-1:0] busy_line;
  logic               look_valid, look_dirty;
  logic [TAG_W-1:0]   look_tag;
  logic               upd_en, upd_clr_valid, upd_clr_dirty;
  logic               pa_valid;
  logic [TAG_W-1:0]   pa_tag;
  logic               fill_en;

  assign fill_en = acc_valid && acc_ready;

  cmo_ctrl #(
    .IDX_W          (IDX_W),
    .TAG_W          (TAG_W),
    .INVAL_AS_FLUSH (INVAL_AS_FLUSH)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_line      (cmd_line),
    .cmd_ready     (cmd_ready),
    .acc_ready     (acc_ready),
    .line_q        (busy_line),
    .look_valid    (look_valid),
    .look_dirty    (look_dirty),
    .look_tag      (look_tag),
    .wb_valid      (wb_valid),
    .wb_ready      (wb_ready),
    .upd_en        (upd_en),
    .upd_clr_valid (upd_clr_valid),
    .upd_clr_dirty (upd_clr_dirty),
    .done          (done),
    .err           (err)
  );

  cmo_line_store #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .fill_en       (fill_en),
    .fill_idx      (acc_line[IDX_W-1:0]),
    .fill_tag      (acc_line[LADDR_W-1:IDX_W]),
    .fill_data     (acc_wdata),
    .fill_dirty    (acc_write),
    .upd_en        (upd_en),
    .upd_idx       (busy_line[IDX_W-1:0]),
    .upd_clr_valid (upd_clr_valid),
    .upd_clr_dirty (upd_clr_dirty),
    .rda_idx       (probe_line[IDX_W-1:0]),
    .rda_valid     (pa_valid),
    .rda_tag       (pa_tag),
    .rda_data      (probe_data),
    .rdb_idx       (busy_line[IDX_W-1:0]),
    .rdb_valid     (look_valid),
    .rdb_dirty     (look_dirty),
    .rdb_tag       (look_tag),
    .rdb_data      (wb_data)
  );

  assign probe_hit = pa_valid && (pa_tag == probe_line[LADDR_W-1:IDX_W]);
  assign wb_addr   = {busy_line, {OFF_W{1'b0}}};

endmodule

// File: rtl/cmo_unit_chk.sv
module cmo_unit_chk #(
  parameter int ADDR_W = 12,
  parameter int LINE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              done,
  input logic              err,
  input logic              acc_ready,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [LINE_W-1:0] wb_data
);

  // R7: acceptance makes both ports busy and no done follows at once
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && !acc_ready && !done));

  // R7: completion pulse lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done is only seen while the engine is still busy
  a_r7_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_ready);

  // R1: error flag only with completion
  a_r1_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R8: pending write-back holds
  a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  // R9: no access while a write-back is pending
  a_r9_no_access_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !acc_ready);

  // R12: line update cycle separates handshake from done
  a_r12_wb_then_update: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> (!done && !wb_valid));

endmodule

bind cmo_unit cmo_unit_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .done      (done),
  .err       (err),
  .acc_ready (acc_ready),
  .wb_valid  (wb_valid),
  .wb_ready  (wb_ready),
  .wb_addr   (wb_addr),
  .wb_data   (wb_data)
);

// File: tb/cmo_unit_tb.sv
module cmo_unit_tb_top;

  localparam int ADDR_W  = 12;
  localparam int LINE_W  = 64;
  localparam int IDX_W   = 3;
  localparam int OFF_W   = 3;
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int TAG_W   = LADDR_W - IDX_W;
  localparam int DEPTH   = 1 << IDX_W;

  logic clk, rst_n;
  logic sel;
  logic cmd_valid, acc_valid, acc_write, wb_ready;
  logic [1:0] cmd_op;
  logic [LADDR_W-1:0] cmd_line, acc_line, probe_line;
  logic [LINE_W-1:0] acc_wdata;

  logic c_rdy[2], a_rdy[2], dn[2], er[2], ph[2], wv[2];
  logic [LINE_W-1:0] pd[2], wd[2];
  logic [ADDR_W-1:0] wa[2];

  logic v_cmd_ready, v_acc_ready, v_done, v_err, v_hit, v_wb_valid;
  logic [LINE_W-1:0] v_pdata, v_wdata;
  logic [ADDR_W-1:0] v_waddr;

  int n_chk, n_fail;
  bit finished;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  cmo_unit #(.INVAL_AS_FLUSH(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid && !sel), .cmd_ready(c_rdy[0]), .cmd_op(cmd_op), .cmd_line(cmd_line),
    .done(dn[0]), .err(er[0]),
    .acc_valid(acc_valid && !sel), .acc_ready(a_rdy[0]), .acc_write(acc_write),
    .acc_line(acc_line), .acc_wdata(acc_wdata),
    .probe_line(probe_line), .probe_hit(ph[0]), .probe_data(pd[0]),
    .wb_valid(wv[0]), .wb_ready(wb_ready), .wb_addr(wa[0]), .wb_data(wd[0])
  );

  cmo_unit #(.INVAL_AS_FLUSH(1'b1)) dut_f (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid && sel), .cmd_ready(c_rdy[1]), .cmd_op(cmd_op), .cmd_line(cmd_line),
    .done(dn[1]), .err(er[1]),
    .acc_valid(acc_valid && sel), .acc_ready(a_rdy[1]), .acc_write(acc_write),
    .acc_line(acc_line), .acc_wdata(acc_wdata),
    .probe_line(probe_line), .probe_hit(ph[1]), .probe_data(pd[1]),
    .wb_valid(wv[1]), .wb_ready(wb_ready), .wb_addr(wa[1]), .wb_data(wd[1])
  );

  always_comb begin
    v_cmd_ready = c_rdy[sel];
    v_acc_ready = a_rdy[sel];
    v_done      = dn[sel];
    v_err       = er[sel];
    v_hit       = ph[sel];
    v_pdata     = pd[sel];
    v_wb_valid  = wv[sel];
    v_waddr     = wa[sel];
    v_wdata     = wd[sel];
  end

  // Reference model
  logic             mv  [2][DEPTH];
  logic             md  [2][DEPTH];
  logic [TAG_W-1:0] mt  [2][DEPTH];
  logic [LINE_W-1:0] mdat[2][DEPTH];

  // Results of the last command
  int r_wb_cnt, r_lat, r_viol;
  logic r_err;
  logic [ADDR_W-1:0] r_waddr;
  logic [LINE_W-1:0] r_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_acc(input logic wr, input logic [LADDR_W-1:0] line, input logic [LINE_W-1:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_line = line; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    mv[sel][line[IDX_W-1:0]]   = 1'b1;
    md[sel][line[IDX_W-1:0]]   = wr;
    mt[sel][line[IDX_W-1:0]]   = line[LADDR_W-1:IDX_W];
    mdat[sel][line[IDX_W-1:0]] = d;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [LADDR_W-1:0] line, input int dly);
    int waited;
    bit fin;
    logic [ADDR_W-1:0] first_a;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_line = line;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_wb_cnt = 0; r_lat = -1; r_viol = 0; r_err = 1'b0; waited = 0; fin = 0;
    first_a = '0;
    for (int n = 0; n < 40 && !fin; n++) begin
      if (n > 0) @(negedge clk);
      if (wb_ready) begin
        r_wb_cnt++;
        wb_ready = 1'b0;
      end
      if (v_done) begin
        r_lat = n; r_err = v_err; fin = 1;
      end
      if (v_cmd_ready || v_acc_ready) r_viol++;
      if (v_wb_valid) begin
        if (waited == 0) first_a = v_waddr;
        else if (v_waddr != first_a) r_viol++;
        if (waited == dly) begin
          wb_ready = 1'b1;
          r_waddr  = v_waddr;
          r_wdata  = v_wdata;
        end
        waited++;
      end
    end
  endtask

  task automatic do_probe(input logic [LADDR_W-1:0] line);
    @(negedge clk);
    probe_line = line;
    #1;
  endtask

  initial begin
    finished = 0;
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int k;
    n_chk = 0; n_fail = 0;
    sel = 1'b0; rst_n = 1'b0;
    cmd_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; wb_ready = 1'b0;
    cmd_op = '0; cmd_line = '0; acc_line = '0; acc_wdata = '0; probe_line = '0;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < DEPTH; i++) begin
        mv[m][i] = 0; md[m][i] = 0; mt[m][i] = '0; mdat[m][i] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state on both configurations
    for (int m = 0; m < 2; m++) begin
      sel = m[0];
      do_probe('0);
      chk(v_cmd_ready && v_acc_ready, "R10", "ready after reset", {62'd0, v_cmd_ready, v_acc_ready}, 64'd3);
      chk(!v_wb_valid && !v_done && !v_err, "R10", "wb/done/err after reset",
          {61'd0, v_wb_valid, v_done, v_err}, 64'd0);
      for (int i = 0; i < DEPTH; i++) begin
        do_probe(LADDR_W'(i));
        chk(!v_hit, "R10", "line invalid after reset", {63'd0, v_hit}, 64'd0);
      end
    end

    k = 0;
    for (int m = 0; m < 2; m++) begin
      sel = m[0];
      for (int op = 0; op < 4; op++)
        for (int cond = 0; cond < 3; cond++)
          for (int miss = 0; miss < 2; miss++) begin
            logic [IDX_W-1:0] idx;
            logic [TAG_W-1:0] tg, ctg;
            logic [LINE_W-1:0] d;
            logic [LADDR_W-1:0] ln;
            bit hit, dirty, e_wb, e_valid, e_dirty;
            int e_lat, dly;
            string rq;
            idx = IDX_W'(k % DEPTH);
            tg  = TAG_W'((k * 5 + 1) % 32);
            d   = ({56'd0, 8'(k)} * 64'h0101_0101_0101_0101) ^ 64'h5A3C_96E1_0F24_7BD8;
            ln  = {tg, idx};
            dly = k % 3;
            // Prepare the line
            do_acc(cond == 2, ln, d);
            if (cond == 0) begin
              run_cmd(2'b10, ln, 0);
              mv[sel][idx] = 0; md[sel][idx] = 0;
            end
            ctg = miss ? (tg ^ TAG_W'(6'h20)) : tg;
            // Expected outcome
            hit   = mv[sel][idx] && (mt[sel][idx] == ctg);
            dirty = md[sel][idx];
            e_valid = mv[sel][idx]; e_dirty = dirty;
            e_wb = 0;
            case (op)
              0: begin e_wb = hit && dirty && (m == 1); if (hit) begin e_valid = 0; e_dirty = 0; end
                        rq = (m == 1) ? "R3" : "R2"; end
              1: begin e_wb = hit && dirty; if (hit) e_dirty = 0; rq = "R4"; end
              2: begin e_wb = hit && dirty; if (hit) begin e_valid = 0; e_dirty = 0; end rq = "R5"; end
              default: rq = "R1";
            endcase
            if (!hit && op != 3) rq = "R6";
            e_lat = e_wb ? 3 + dly : ((hit && op != 3) ? 2 : 1);
            run_cmd(op[1:0], {ctg, idx}, dly);
            chk(r_wb_cnt == (e_wb ? 1 : 0), rq, "write-back count", 64'(r_wb_cnt), e_wb ? 64'd1 : 64'd0);
            if (e_wb) begin
              chk(r_waddr == {tg, idx, 3'b000}, "R11", "write-back address", 64'(r_waddr), 64'({tg, idx, 3'b000}));
              chk(r_wdata == d, "R11", "write-back data", r_wdata, d);
            end
            chk(r_lat == e_lat, "R12", "done latency", 64'(r_lat), 64'(e_lat));
            chk(r_err == (op == 3), "R1", "error flag", {63'd0, r_err}, (op == 3) ? 64'd1 : 64'd0);
            chk(r_viol == 0, "R7", "busy/stability violations", 64'(r_viol), 64'd0);
            mv[sel][idx] = e_valid; md[sel][idx] = e_dirty;
            // Surviving state through the probe port
            do_probe({tg, idx});
            chk(v_hit == e_valid, rq, "line valid after command", {63'd0, v_hit}, {63'd0, e_valid});
            if (e_valid)
              chk(v_pdata == d, rq, "line data kept", v_pdata, d);
            // Dirty state through a follow-up clean
            if (e_valid) begin
              run_cmd(2'b01, {tg, idx}, 0);
              chk(r_wb_cnt == (e_dirty ? 1 : 0), (op == 1) ? "R4" : rq, "dirty state via clean",
                  64'(r_wb_cnt), e_dirty ? 64'd1 : 64'd0);
              md[sel][idx] = 0;
            end
            k++;
          end
    end

    finished = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule